// File: doc/BRIEF.md
# Speculative Cache Line State Tracker

This block keeps the per-line bookkeeping a private cache needs to run speculative threads. It is a direct-mapped array of line records. Each record holds an address tag, a four-state coherence state, a flag that marks a speculative read and a flag that marks a speculative write. Local loads and stores update the flags on a hit. Incoming invalidations carry the epoch number of the writing thread, so the block can tell whether a less speculative thread has written a word that this thread has already read. Such a read-after-write hazard, or the eviction of a flagged line, raises a sticky violation output.

An external sequencer resolves each epoch with a single-cycle squash or a single-cycle commit. A squash discards every speculatively written line and clears all flags. A commit promotes speculatively written exclusive lines to dirty and clears the read flags at once. Speculatively written shared lines cannot be promoted until ownership is granted, so the block offers them one at a time on an ownership request port until an external engine has acknowledged each one. Line data, the bus protocol and the fill path sit outside the block; a fill is an input that installs a tag and a state.

Top module: `spec_line_tracker`

## Requirements
- R1: After reset every line is Invalid with both flags clear, `violation_o` is low and `own_req_o` is low.
- R2: A fill writes the tag and the given state into the line at the index. The index is the low log2(NUM_LINES) address bits and the tag is the remaining upper bits. State codes are Invalid 0, Shared 1, Exclusive 2, Dirty 3. The lookup port reports a hit when the indexed line is not Invalid and its tag matches. On a hit it reports the line's state, and on a miss it reports Invalid with the flags low.
- R3: A speculative load that hits sets the line's read flag. A load that misses changes nothing.
- R4: A speculative store that hits sets the write flag and leaves the state unchanged. On a Shared line this gives speculative-shared, and on an Exclusive line it gives speculative-exclusive. A plain store that hits an Exclusive line makes it Dirty.
- R5: A speculative invalidation whose epoch is numerically lower than `local_epoch_i` and that hits a line with the read flag set raises `violation_o` from the next cycle. The line is kept. `violation_o` stays high until a squash.
- R6: A speculative invalidation whose epoch is equal to or higher than `local_epoch_i` never raises a violation. It leaves a flagged line unchanged and makes an unflagged hit line Invalid.
- R7: A plain invalidation makes an unflagged hit line Invalid with no violation. If it hits a line with the read flag set, it raises a violation and the line is kept.
- R8: A fill into a slot whose current line has either flag set raises a violation. The new line is still installed.
- R9: A squash makes every line with the write flag Invalid, clears all flags, clears `violation_o` and cancels any pending ownership requests, all in one cycle.
- R10: A commit turns every write-flagged Exclusive or Dirty line Dirty, clears that flag and clears all read flags in one cycle. Write-flagged Shared lines stay pending. From the next cycle `own_req_o` is high with `own_idx_o` giving the lowest pending index. `own_req_o` is never raised without a commit.
- R11: `own_ack_i` while `own_req_o` is high makes the offered line Dirty and clears its write flag. `own_req_o` drops once no line is pending. `own_ack_i` is ignored while `own_req_o` is low. While a request is neither acknowledged nor disturbed, `own_idx_o` holds.
- R12: At most one operation takes effect per cycle, in this priority: squash, commit, acknowledged ownership, invalidation, fill, local access. Lower-priority inputs in that cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| local_epoch_i | input | EPOCH_W | Epoch number of the local thread |
| req_valid_i | input | 1 | Local access strobe |
| req_write_i | input | 1 | Local access is a store |
| req_spec_i | input | 1 | Local access is speculative |
| req_addr_i | input | ADDR_W | Local access address, also the lookup address |
| fill_valid_i | input | 1 | Install a line |
| fill_addr_i | input | ADDR_W | Address of the installed line |
| fill_state_i | input | 2 | State of the installed line |
| inv_valid_i | input | 1 | Incoming invalidation strobe |
| inv_spec_i | input | 1 | Invalidation comes from a speculative writer |
| inv_epoch_i | input | EPOCH_W | Epoch number of the writer |
| inv_addr_i | input | ADDR_W | Invalidated address |
| squash_i | input | 1 | Discard speculative work |
| commit_i | input | 1 | Make speculative work permanent |
| own_ack_i | input | 1 | Ownership granted for the offered line |
| look_hit_o | output | 1 | Lookup hit for `req_addr_i` |
| look_state_o | output | 2 | Lookup state |
| look_sl_o | output | 1 | Lookup read flag |
| look_sm_o | output | 1 | Lookup write flag |
| violation_o | output | 1 | Sticky speculation failure |
| own_req_o | output | 1 | A committed shared line needs ownership |
| own_idx_o | output | log2(NUM_LINES) | Index of the line offered |

## Verification
The lookup outputs are combinational on `req_addr_i` but read registered line records. The effect of an operation applied at a rising edge therefore shows on the lookup port straight after that edge. `violation_o`, `own_req_o` and `own_idx_o` are registered or decoded from registered state, so they also change in the cycle that follows the operation's edge. The bench drives each operation at a falling edge, removes it at the next falling edge, and only then samples the lookup and status outputs. The operation's edge thus lies between drive and check. For simultaneous inputs (priority), the bench asserts them all in the same half-cycle and samples once after the single edge.

// File: rtl/slt_pkg.sv
package slt_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } line_st_e;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_SQUASH,
    OP_COMMIT,
    OP_ACK,
    OP_INV,
    OP_FILL,
    OP_LOAD,
    OP_STORE
  } line_op_e;
endpackage

// File: rtl/slt_line.sv
module slt_line
  import slt_pkg::*;
#(
  parameter int unsigned TAG_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  line_op_e         op_i,
  input  logic             sel_i,
  input  logic [TAG_W-1:0] op_tag_i,
  input  logic             op_spec_i,
  input  line_st_e         fill_st_i,
  output logic [TAG_W-1:0] tag_o,
  output line_st_e         state_o,
  output logic             sl_o,
  output logic             sm_o
);
  logic [TAG_W-1:0] tag_q, tag_d;
  line_st_e         st_q, st_d;
  logic             sl_q, sl_d, sm_q, sm_d;
  logic             hit;

  assign hit = (st_q != ST_I) && (tag_q == op_tag_i);

  always_comb begin
    tag_d = tag_q;
    st_d  = st_q;
    sl_d  = sl_q;
    sm_d  = sm_q;
    unique case (op_i)
      OP_SQUASH: begin
        if (sm_q) st_d = ST_I;
        sl_d = 1'b0;
        sm_d = 1'b0;
      end
      OP_COMMIT: begin
        sl_d = 1'b0;
        // shared lines keep SM until ownership arrives
        if (sm_q && st_q != ST_S) begin
          st_d = ST_M;
          sm_d = 1'b0;
        end
      end
      OP_ACK: begin
        if (sel_i && sm_q && st_q == ST_S) begin
          st_d = ST_M;
          sm_d = 1'b0;
        end
      end
      OP_INV: begin
        if (sel_i && hit && !sl_q && !sm_q) st_d = ST_I;
      end
      OP_FILL: begin
        if (sel_i) begin
          tag_d = op_tag_i;
          st_d  = fill_st_i;
          sl_d  = 1'b0;
          sm_d  = 1'b0;
        end
      end
      OP_LOAD: begin
        if (sel_i && hit && op_spec_i) sl_d = 1'b1;
      end
      OP_STORE: begin
        if (sel_i && hit) begin
          if (op_spec_i) sm_d = 1'b1;
          else if (st_q == ST_E) st_d = ST_M;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q <= '0;
      st_q  <= ST_I;
      sl_q  <= 1'b0;
      sm_q  <= 1'b0;
    end else begin
      tag_q <= tag_d;
      st_q  <= st_d;
      sl_q  <= sl_d;
      sm_q  <= sm_d;
    end
  end

  assign tag_o   = tag_q;
  assign state_o = st_q;
  assign sl_o    = sl_q;
  assign sm_o    = sm_q;
endmodule

// File: rtl/slt_pick.sv
module slt_pick #(
  parameter int unsigned N    = 16,
  parameter int unsigned IW   = 4
) (
  input  logic [N-1:0]  req_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
  assign valid_o = |req_i;
endmodule

// File: rtl/spec_line_tracker.sv
module spec_line_tracker
  import slt_pkg::*;
#(
  parameter int unsigned NUM_LINES = 16,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned EPOCH_W   = 8,
  localparam int unsigned IDX_W    = $clog2(NUM_LINES),
  localparam int unsigned TAG_W    = ADDR_W - IDX_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [EPOCH_W-1:0] local_epoch_i,
  input  logic               req_valid_i,
  input  logic               req_write_i,
  input  logic               req_spec_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic               fill_valid_i,
  input  logic [ADDR_W-1:0]  fill_addr_i,
  input  logic [1:0]         fill_state_i,
  input  logic               inv_valid_i,
  input  logic               inv_spec_i,
  input  logic [EPOCH_W-1:0] inv_epoch_i,
  input  logic [ADDR_W-1:0]  inv_addr_i,
  input  logic               squash_i,
  input  logic               commit_i,
  input  logic               own_ack_i,
  output logic               look_hit_o,
  output logic [1:0]         look_state_o,
  output logic               look_sl_o,
  output logic               look_sm_o,
  output logic               violation_o,
  output logic               own_req_o,
  output logic [IDX_W-1:0]   own_idx_o
);
  line_op_e          op;
  logic [ADDR_W-1:0] op_addr;
  logic [IDX_W-1:0]  op_idx;
  logic [TAG_W-1:0]  op_tag;
  logic              op_spec;

  logic [TAG_W-1:0]  tag_a [NUM_LINES];
  line_st_e          st_a  [NUM_LINES];
  logic [NUM_LINES-1:0] sl_v, sm_v, pend_v;

  logic busy_q, viol_q, pick_valid, viol_evt;
  logic [IDX_W-1:0] pick_idx;

  // single operation per cycle, fixed priority
  always_comb begin
    op      = OP_NONE;
    op_addr = req_addr_i;
    op_spec = req_spec_i;
    if (squash_i)                    op = OP_SQUASH;
    else if (commit_i)               op = OP_COMMIT;
    else if (own_ack_i && own_req_o) op = OP_ACK;
    else if (inv_valid_i) begin
      op      = OP_INV;
      op_addr = inv_addr_i;
      op_spec = inv_spec_i;
    end else if (fill_valid_i) begin
      op      = OP_FILL;
      op_addr = fill_addr_i;
    end else if (req_valid_i)        op = req_write_i ? OP_STORE : OP_LOAD;
  end

  assign op_idx = (op == OP_ACK) ? pick_idx : op_addr[IDX_W-1:0];
  assign op_tag = op_addr[ADDR_W-1:IDX_W];

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    slt_line #(.TAG_W(TAG_W)) u_line (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .op_i      (op),
      .sel_i     (op_idx == IDX_W'(g)),
      .op_tag_i  (op_tag),
      .op_spec_i (op_spec),
      .fill_st_i (line_st_e'(fill_state_i)),
      .tag_o     (tag_a[g]),
      .state_o   (st_a[g]),
      .sl_o      (sl_v[g]),
      .sm_o      (sm_v[g])
    );
    assign pend_v[g] = sm_v[g] && (st_a[g] == ST_S);
  end

  slt_pick #(.N(NUM_LINES), .IW(IDX_W)) u_pick (
    .req_i   (pend_v),
    .valid_o (pick_valid),
    .idx_o   (pick_idx)
  );

  // violation sources: early-epoch or plain write to a read line, eviction of a flagged line
  logic tgt_hit;
  assign tgt_hit  = (st_a[op_idx] != ST_I) && (tag_a[op_idx] == op_tag);
  assign viol_evt = ((op == OP_INV) && tgt_hit && sl_v[op_idx] &&
                     (!inv_spec_i || (inv_epoch_i < local_epoch_i))) ||
                    ((op == OP_FILL) && (sl_v[op_idx] || sm_v[op_idx]));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      viol_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      if (squash_i)      viol_q <= 1'b0;
      else if (viol_evt) viol_q <= 1'b1;

      if (squash_i)         busy_q <= 1'b0;
      else if (commit_i)    busy_q <= 1'b1;
      else if (!pick_valid) busy_q <= 1'b0;
    end
  end

  assign violation_o = viol_q;
  assign own_req_o   = busy_q && pick_valid;
  assign own_idx_o   = pick_idx;

  logic [IDX_W-1:0] look_idx;
  assign look_idx     = req_addr_i[IDX_W-1:0];
  assign look_hit_o   = (st_a[look_idx] != ST_I) && (tag_a[look_idx] == req_addr_i[ADDR_W-1:IDX_W]);
  assign look_state_o = look_hit_o ? st_a[look_idx] : ST_I;
  assign look_sl_o    = look_hit_o && sl_v[look_idx];
  assign look_sm_o    = look_hit_o && sm_v[look_idx];
endmodule

// File: rtl/slt_checker.sv
module slt_checker #(
  parameter int unsigned NUM_LINES = 16,
  parameter int unsigned EPOCH_W   = 8,
  localparam int unsigned IDX_W    = $clog2(NUM_LINES)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [EPOCH_W-1:0] local_epoch_i,
  input logic               req_valid_i,
  input logic               fill_valid_i,
  input logic               inv_valid_i,
  input logic               inv_spec_i,
  input logic [EPOCH_W-1:0] inv_epoch_i,
  input logic               squash_i,
  input logic               commit_i,
  input logic               own_ack_i,
  input logic               look_sl_o,
  input logic               look_sm_o,
  input logic               violation_o,
  input logic               own_req_o,
  input logic [IDX_W-1:0]   own_idx_o
);
  AST_SQUASH_CLR_VIOL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_i |=> !violation_o); // R9
  AST_SQUASH_CLR_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_i |=> (!look_sl_o && !look_sm_o)); // R9
  AST_SQUASH_NO_OWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_i |=> !own_req_o); // R9
  AST_COMMIT_CLR_SL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && !squash_i) |=> !look_sl_o); // R10
  AST_OWN_NEEDS_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!own_req_o && !commit_i) |=> !own_req_o); // R10
  AST_VIOL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (violation_o && !squash_i) |=> violation_o); // R5
  AST_LATE_INV_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_valid_i && inv_spec_i && (inv_epoch_i >= local_epoch_i) && !squash_i &&
     !commit_i && !(own_req_o && own_ack_i) && !violation_o) |=> !violation_o); // R6
  AST_OWN_IDX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_req_o && !own_ack_i && !squash_i && !commit_i && !fill_valid_i && !req_valid_i)
    |=> (own_req_o && $stable(own_idx_o))); // R11
endmodule

bind spec_line_tracker slt_checker #(
  .NUM_LINES (NUM_LINES),
  .EPOCH_W   (EPOCH_W)
) u_slt_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .local_epoch_i (local_epoch_i),
  .req_valid_i   (req_valid_i),
  .fill_valid_i  (fill_valid_i),
  .inv_valid_i   (inv_valid_i),
  .inv_spec_i    (inv_spec_i),
  .inv_epoch_i   (inv_epoch_i),
  .squash_i      (squash_i),
  .commit_i      (commit_i),
  .own_ack_i     (own_ack_i),
  .look_sl_o     (look_sl_o),
  .look_sm_o     (look_sm_o),
  .violation_o   (violation_o),
  .own_req_o     (own_req_o),
  .own_idx_o     (own_idx_o)
);

// File: tb/tb_spec_line_tracker.sv
module tb_spec_line_tracker;
  localparam int unsigned AW = 16;
  localparam int unsigned EW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [EW-1:0] local_epoch = 8'd5;
  logic req_valid = 0, req_write = 0, req_spec = 0;
  logic [AW-1:0] req_addr = '0;
  logic fill_valid = 0;
  logic [AW-1:0] fill_addr = '0;
  logic [1:0] fill_state = '0;
  logic inv_valid = 0, inv_spec = 0;
  logic [EW-1:0] inv_epoch = '0;
  logic [AW-1:0] inv_addr = '0;
  logic squash = 0, commit = 0, own_ack = 0;
  logic look_hit, look_sl, look_sm, violation, own_req;
  logic [1:0] look_state;
  logic [3:0] own_idx;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  spec_line_tracker dut (
    .clk_i(clk), .rst_ni(rst_n), .local_epoch_i(local_epoch),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_spec_i(req_spec),
    .req_addr_i(req_addr), .fill_valid_i(fill_valid), .fill_addr_i(fill_addr),
    .fill_state_i(fill_state), .inv_valid_i(inv_valid), .inv_spec_i(inv_spec),
    .inv_epoch_i(inv_epoch), .inv_addr_i(inv_addr), .squash_i(squash),
    .commit_i(commit), .own_ack_i(own_ack), .look_hit_o(look_hit),
    .look_state_o(look_state), .look_sl_o(look_sl), .look_sm_o(look_sm),
    .violation_o(violation), .own_req_o(own_req), .own_idx_o(own_idx)
  );

  // op codes: 0 fill, 1 spec load, 2 spec store, 3 plain store, 4 spec inv,
  // 5 plain inv, 6 squash, 7 commit, 8 ack, 9 probe only
  typedef struct packed {
    logic [3:0]  rq;
    logic [3:0]  op;
    logic [15:0] addr;
    logic [7:0]  arg;
    logic        hit;
    logic [1:0]  st;
    logic        sl;
    logic        sm;
    logic        viol;
    logic        own;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VECS [NV] = '{
    '{4'd2,  4'd0, 16'h0013, 8'd2, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0}, // R2
    '{4'd3,  4'd1, 16'h0013, 8'd0, 1'b1, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0}, // R3
    '{4'd6,  4'd4, 16'h0013, 8'd7, 1'b1, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0}, // R6 higher epoch
    '{4'd6,  4'd4, 16'h0013, 8'd5, 1'b1, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0}, // R6 equal epoch
    '{4'd5,  4'd4, 16'h0013, 8'd3, 1'b1, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0}, // R5
    '{4'd9,  4'd6, 16'h0013, 8'd0, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0}, // R9 read-only line kept
    '{4'd4,  4'd2, 16'h0013, 8'd0, 1'b1, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0}, // R4 spec-exclusive
    '{4'd9,  4'd6, 16'h0013, 8'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R9 written line dropped
    '{4'd2,  4'd0, 16'h0024, 8'd1, 1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0}, // R2
    '{4'd4,  4'd2, 16'h0024, 8'd0, 1'b1, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0}, // R4 spec-shared
    '{4'd2,  4'd0, 16'h0035, 8'd2, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0}, // R2
    '{4'd4,  4'd2, 16'h0035, 8'd0, 1'b1, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0}, // R4
    '{4'd3,  4'd1, 16'h0024, 8'd0, 1'b1, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0}, // R3
    '{4'd10, 4'd7, 16'h0035, 8'd0, 1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1}, // R10 promote
    '{4'd10, 4'd9, 16'h0024, 8'd0, 1'b1, 2'd1, 1'b0, 1'b1, 1'b0, 1'b1}, // R10 pending
    '{4'd11, 4'd8, 16'h0024, 8'd0, 1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0}, // R11
    '{4'd2,  4'd0, 16'h0046, 8'd2, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0}, // R2
    '{4'd7,  4'd5, 16'h0046, 8'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R7 plain clear
    '{4'd2,  4'd0, 16'h0057, 8'd1, 1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0}, // R2
    '{4'd3,  4'd1, 16'h0057, 8'd0, 1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0}, // R3
    '{4'd8,  4'd0, 16'h0157, 8'd2, 1'b1, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0}, // R8 eviction
    '{4'd9,  4'd6, 16'h0157, 8'd0, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0}, // R9
    '{4'd4,  4'd3, 16'h0157, 8'd0, 1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 plain store
    '{4'd3,  4'd1, 16'h0157, 8'd0, 1'b1, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0}, // R3
    '{4'd7,  4'd5, 16'h0157, 8'd0, 1'b1, 2'd3, 1'b1, 1'b0, 1'b1, 1'b0}, // R7 plain on read line
    '{4'd9,  4'd6, 16'h0157, 8'd0, 1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0}, // R9
    '{4'd3,  4'd1, 16'h0999, 8'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 miss
    '{4'd6,  4'd4, 16'h0035, 8'd9, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0}  // R6 unflagged cleared
  };

  task automatic chk(input int rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL R%0d %s actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic idle();
    req_valid = 0; req_write = 0; req_spec = 0;
    fill_valid = 0; inv_valid = 0; inv_spec = 0;
    squash = 0; commit = 0; own_ack = 0;
  endtask

  // drive at a falling edge, hold across one rising edge, release and settle
  task automatic step(input logic [3:0] op, input logic [15:0] addr, input logic [7:0] arg);
    @(negedge clk);
    idle();
    req_addr = addr;
    case (op)
      4'd0: begin fill_valid = 1; fill_addr = addr; fill_state = arg[1:0]; end
      4'd1: begin req_valid = 1; req_spec = 1; end
      4'd2: begin req_valid = 1; req_spec = 1; req_write = 1; end
      4'd3: begin req_valid = 1; req_write = 1; end
      4'd4: begin inv_valid = 1; inv_spec = 1; inv_addr = addr; inv_epoch = arg; end
      4'd5: begin inv_valid = 1; inv_addr = addr; inv_epoch = arg; end
      4'd6: squash = 1;
      4'd7: commit = 1;
      4'd8: own_ack = 1;
      default: ;
    endcase
    @(negedge clk);
    idle();
    #1;
  endtask

  function automatic logic [6:0] obs();
    return {look_hit, look_state, look_sl, look_sm, violation, own_req};
  endfunction

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    for (int a = 0; a < 16; a++) begin
      req_addr = 16'(a * 17);
      #1;
      chk(1, "reset lookup", {25'd0, obs()}, 32'd0);
    end

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].op, VECS[i].addr, VECS[i].arg);
      chk(int'(VECS[i].rq), $sformatf("vector %0d", i), {25'd0, obs()},
          {25'd0, VECS[i].hit, VECS[i].st, VECS[i].sl, VECS[i].sm, VECS[i].viol, VECS[i].own});
    end

    // R12 squash beats invalidation and fill
    step(4'd0, 16'h0013, 8'd2);
    step(4'd1, 16'h0013, 8'd0);
    @(negedge clk);
    idle();
    squash = 1; inv_valid = 1; inv_spec = 1; inv_epoch = 8'd1; inv_addr = 16'h0013;
    fill_valid = 1; fill_addr = 16'h0113; fill_state = 2'd1; req_addr = 16'h0013;
    @(negedge clk); idle(); #1;
    chk(12, "squash wins", {25'd0, obs()}, {25'd0, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0});

    // R12 invalidation beats fill
    step(4'd1, 16'h0013, 8'd0);
    @(negedge clk);
    idle();
    inv_valid = 1; inv_spec = 1; inv_epoch = 8'd1; inv_addr = 16'h0013;
    fill_valid = 1; fill_addr = 16'h0113; fill_state = 2'd1; req_addr = 16'h0013;
    @(negedge clk); idle(); #1;
    chk(12, "inv wins over fill", {25'd0, obs()}, {25'd0, 1'b1, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0});
    step(4'd6, 16'h0013, 8'd0);

    // R10 lowest pending index offered first, R11 ack walks the list
    step(4'd0, 16'h0082, 8'd1);
    step(4'd0, 16'h0068, 8'd1);
    step(4'd2, 16'h0082, 8'd0);
    step(4'd2, 16'h0068, 8'd0);
    step(4'd7, 16'h0082, 8'd0);
    chk(10, "first offer", {27'd0, own_req, own_idx}, {27'd0, 1'b1, 4'd2});
    step(4'd8, 16'h0082, 8'd0);
    chk(11, "second offer", {27'd0, own_req, own_idx}, {27'd0, 1'b1, 4'd8});
    chk(11, "acked line dirty", {25'd0, obs()}, {25'd0, 1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1});
    step(4'd8, 16'h0068, 8'd0);
    chk(11, "offers done", {25'd0, obs()}, {25'd0, 1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0});

    // R11 ack without request has no effect
    step(4'd0, 16'h0093, 8'd1);
    step(4'd2, 16'h0093, 8'd0);
    step(4'd8, 16'h0093, 8'd0);
    chk(11, "idle ack ignored", {25'd0, obs()}, {25'd0, 1'b1, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0});
    step(4'd6, 16'h0093, 8'd0);
    chk(9, "squash drops spec-shared", {25'd0, obs()}, 32'd0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule